// File: doc/BRIEF.md
# Chip-Select Decoder with Sticky Select Latches

This block sits beside a small microcontroller that reaches its peripherals through table-read and table-write accesses. On each access strobe it decodes the top three address bits into one of eight 8 KB regions. In the cycle after the strobe it pulls that region's active-low chip select low for exactly one cycle.

Three of the regions also drive sticky select latches: two for the halves of a character display, and one for a keypad/buzzer port. A fourth latch records that a write access took place. The latches interact. Selecting either display half drops the keypad latch, and selecting the keypad drops both display latches. One shared control line also serves as the display's register-select. Holding that line low clears the select latches. A falling edge on it clears the write latch.

The keypad port gets an output enable that follows its latch, so the keypad data lines float whenever the latch is clear. A write into the keypad region also turns on a buzzer drive. The keypad's data-available flag passes straight through as an interrupt request.

Top module: `chip_sel_latch`

## Requirements
- R1: When `tbl_stb` is high at a rising edge, `cs_n[addr_hi]` is low during the next cycle and every other bit of `cs_n` is high. In a cycle that follows no strobe, `cs_n` is all ones.
- R2: A strobe to region 5 sets `disp_a` and clears `disp_b`. A strobe to region 6 sets `disp_b` and clears `disp_a`. The two are never high together.
- R3: A strobe to region 5 or 6 clears `key_sel`. A strobe to region 7 sets `key_sel` and clears both display latches.
- R4: At every edge where `ctl_line` is low, `disp_a`, `disp_b`, `key_sel` and `buzz` become 0, even if a strobe to region 5, 6 or 7 arrives in the same cycle.
- R5: Any strobe with `tbl_wr` high sets `wr_latch`. A high-to-low transition of `ctl_line` between two edges clears it. If both happen at the same edge, the set wins. A low level with no transition does not clear it.
- R6: `reg_sel` equals `ctl_line` and `key_irq` equals `key_avail` in the same cycle, with no register between them.
- R7: `key_oe` is high exactly while `key_sel` is high.
- R8: A strobe to region 7 sets `buzz` to the value of `tbl_wr`. After that, `buzz` stays high only while `key_sel` stays high.
- R9: Strobes to regions 0 to 4 change no latch. They produce only their chip-select pulse, apart from setting `wr_latch` under R5.
- R10: At a rising edge with `rst` high, every latch clears and `cs_n` becomes all ones. The stored copy of `ctl_line` is set high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle |
| rst | input | 1 | Synchronous reset, active high |
| addr_hi | input | 3 | Upper address bits of the access |
| tbl_stb | input | 1 | Table access strobe, one cycle per access |
| tbl_wr | input | 1 | High for a table write, low for a read |
| ctl_line | input | 1 | Shared control line, also the display register-select |
| key_avail | input | 1 | Keypad data-available flag |
| cs_n | output | 8 | Active-low one-cycle chip selects |
| disp_a | output | 1 | Display half A select latch |
| disp_b | output | 1 | Display half B select latch |
| key_sel | output | 1 | Keypad/buzzer select latch |
| wr_latch | output | 1 | Write-direction latch |
| reg_sel | output | 1 | Display register-select, follows ctl_line |
| key_oe | output | 1 | Keypad data output enable |
| buzz | output | 1 | Buzzer drive |
| key_irq | output | 1 | Keypad interrupt request |

## Verification
The chip selects, the four latches, the buzzer and the keypad enable are all registered. Each one shows the effect of a stimulus exactly one edge after the inputs are applied. The bench drives on the falling edge, waits for one rising edge and compares on the next falling edge, so every registered result is sampled in the cycle it is due. The register-select and interrupt outputs are combinational and are checked one time unit after the inputs change, before any edge. The sweep walks every starting latch state through every region with both access directions. It also covers the low control level, the falling edge and the cycles where a strobe and an edge coincide.

// File: rtl/csd_pkg.sv
package csd_pkg;
    typedef struct packed {
        logic disp_a;
        logic disp_b;
        logic key;
        logic wr;
        logic buzz;
        logic ctl_prev;
    } latch_t;

    localparam latch_t LATCH_RESET = '{disp_a: 1'b0, disp_b: 1'b0, key: 1'b0,
                                       wr: 1'b0, buzz: 1'b0, ctl_prev: 1'b1};
endpackage

// File: rtl/csd_region_dec.sv
module csd_region_dec #(
    parameter int SEL_W = 3,
    localparam int NCS  = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] addr_hi,
    input  logic             stb,
    output logic [NCS-1:0]   hit
);
    for (genvar i = 0; i < NCS; i++) begin : g_hit
        assign hit[i] = stb && (addr_hi == SEL_W'(i));
    end
endmodule

// File: rtl/csd_latch_next.sv
module csd_latch_next
    import csd_pkg::*;
#(
    parameter int NCS     = 8,
    parameter int DA_IDX  = 5,
    parameter int DB_IDX  = 6,
    parameter int KEY_IDX = 7
) (
    input  logic [NCS-1:0] hit,
    input  logic           wr,
    input  logic           ctl,
    input  latch_t         cur,
    output latch_t         nxt
);
    logic hit_a, hit_b, hit_k, fall;

    always_comb begin
        hit_a = hit[DA_IDX];
        hit_b = hit[DB_IDX];
        hit_k = hit[KEY_IDX];
        fall  = cur.ctl_prev && !ctl;

        nxt          = cur;
        nxt.ctl_prev = ctl;
        nxt.wr       = ((|hit) && wr) || (cur.wr && !fall);

        if (!ctl) begin
            nxt.disp_a = 1'b0;
            nxt.disp_b = 1'b0;
            nxt.key    = 1'b0;
            nxt.buzz   = 1'b0;
        end else begin
            nxt.disp_a = hit_a || (cur.disp_a && !hit_b && !hit_k);
            nxt.disp_b = hit_b || (cur.disp_b && !hit_a && !hit_k);
            nxt.key    = hit_k || (cur.key && !hit_a && !hit_b);
            nxt.buzz   = hit_k ? wr : (cur.buzz && nxt.key);
        end
    end
endmodule

// File: rtl/chip_sel_latch.sv
module chip_sel_latch
    import csd_pkg::*;
#(
    parameter int SEL_W   = 3,
    parameter int DA_IDX  = 5,
    parameter int DB_IDX  = 6,
    parameter int KEY_IDX = 7,
    localparam int NCS    = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] addr_hi,
    input  logic             tbl_stb,
    input  logic             tbl_wr,
    input  logic             ctl_line,
    input  logic             key_avail,
    output logic [NCS-1:0]   cs_n,
    output logic             disp_a,
    output logic             disp_b,
    output logic             key_sel,
    output logic             wr_latch,
    output logic             reg_sel,
    output logic             key_oe,
    output logic             buzz,
    output logic             key_irq
);
    logic [NCS-1:0] hit;
    logic [NCS-1:0] cs_n_d, cs_n_q;
    latch_t         st_d, st_q, st_nxt;

    csd_region_dec #(.SEL_W(SEL_W)) u_dec (
        .addr_hi (addr_hi),
        .stb     (tbl_stb),
        .hit     (hit)
    );

    csd_latch_next #(
        .NCS(NCS), .DA_IDX(DA_IDX), .DB_IDX(DB_IDX), .KEY_IDX(KEY_IDX)
    ) u_next (
        .hit (hit),
        .wr  (tbl_wr),
        .ctl (ctl_line),
        .cur (st_q),
        .nxt (st_nxt)
    );

    always_comb begin
        if (rst) begin
            st_d   = LATCH_RESET;
            cs_n_d = '1;
        end else begin
            st_d   = st_nxt;
            cs_n_d = ~hit;
        end
    end

    always_ff @(posedge clk) begin
        st_q   <= st_d;
        cs_n_q <= cs_n_d;
    end

    assign cs_n     = cs_n_q;
    assign disp_a   = st_q.disp_a;
    assign disp_b   = st_q.disp_b;
    assign key_sel  = st_q.key;
    assign wr_latch = st_q.wr;
    assign buzz     = st_q.buzz;
    assign key_oe   = st_q.key;
    assign reg_sel  = ctl_line;
    assign key_irq  = key_avail;
endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
    parameter int SEL_W = 3,
    parameter int NCS   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] addr_hi,
    input logic             tbl_stb,
    input logic             tbl_wr,
    input logic             ctl_line,
    input logic [NCS-1:0]   cs_n,
    input logic             disp_a,
    input logic             disp_b,
    input logic             key_sel,
    input logic             wr_latch,
    input logic             buzz
);
    // R1
    cs_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_stb |=> !cs_n[$past(addr_hi)]);
    // R1
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tbl_stb |=> (&cs_n));
    // R1
    cs_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    // R2
    disp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(disp_a && disp_b));
    // R3
    key_disp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(key_sel && (disp_a || disp_b)));
    // R4
    ctl_low_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_line |=> (!disp_a && !disp_b && !key_sel && !buzz));
    // R5
    wr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tbl_stb && tbl_wr) |=> wr_latch);
    // R5
    wr_fall_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctl_line) && !(tbl_stb && tbl_wr)) |=> !wr_latch);
    // R8
    buzz_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
        buzz |-> key_sel);
endmodule

bind chip_sel_latch csd_checker #(.SEL_W(SEL_W), .NCS(NCS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr_hi  (addr_hi),
    .tbl_stb  (tbl_stb),
    .tbl_wr   (tbl_wr),
    .ctl_line (ctl_line),
    .cs_n     (cs_n),
    .disp_a   (disp_a),
    .disp_b   (disp_b),
    .key_sel  (key_sel),
    .wr_latch (wr_latch),
    .buzz     (buzz)
);

// File: tb/tb_chip_sel_latch.sv
module tb_chip_sel_latch;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] addr_hi;
    logic       tbl_stb, tbl_wr, ctl_line, key_avail;
    logic [7:0] cs_n;
    logic       disp_a, disp_b, key_sel, wr_latch, reg_sel, key_oe, buzz, key_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model state
    logic [7:0] m_cs;
    logic m_a, m_b, m_k, m_w, m_bz, m_ctlq;

    always #(PERIOD/2) clk = ~clk;

    chip_sel_latch dut (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .tbl_stb(tbl_stb),
        .tbl_wr(tbl_wr), .ctl_line(ctl_line), .key_avail(key_avail),
        .cs_n(cs_n), .disp_a(disp_a), .disp_b(disp_b), .key_sel(key_sel),
        .wr_latch(wr_latch), .reg_sel(reg_sel), .key_oe(key_oe),
        .buzz(buzz), .key_irq(key_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string ltag);
        string ta, tk;
        ta = (ltag == "") ? "R2" : ltag;
        tk = (ltag == "") ? "R3" : ltag;
        chk("R1", "cs_n", cs_n, m_cs);
        chk(ta, "disp_a", {7'd0, disp_a}, {7'd0, m_a});
        chk(ta, "disp_b", {7'd0, disp_b}, {7'd0, m_b});
        chk(tk, "key_sel", {7'd0, key_sel}, {7'd0, m_k});
        chk("R5", "wr_latch", {7'd0, wr_latch}, {7'd0, m_w});
        chk("R7", "key_oe", {7'd0, key_oe}, {7'd0, m_k});
        chk("R8", "buzz", {7'd0, buzz}, {7'd0, m_bz});
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic stb, input logic [2:0] reg_n,
                        input logic wr, input logic ctl, input string ltag);
        logic fall;
        tbl_stb  = stb;
        addr_hi  = reg_n;
        tbl_wr   = wr;
        ctl_line = ctl;
        key_avail = reg_n[0] ^ wr;
        #1;
        chk("R6", "reg_sel", {7'd0, reg_sel}, {7'd0, ctl});
        chk("R6", "key_irq", {7'd0, key_irq}, {7'd0, key_avail});
        @(posedge clk);
        fall = m_ctlq && !ctl;
        m_cs = stb ? ~(8'd1 << reg_n) : 8'hFF;
        if (stb && wr) m_w = 1'b1;
        else if (fall) m_w = 1'b0;
        if (!ctl) begin
            m_a = 0; m_b = 0; m_k = 0; m_bz = 0;
        end else if (stb) begin
            case (reg_n)
                3'd5: begin m_a = 1; m_b = 0; m_k = 0; m_bz = 0; end
                3'd6: begin m_a = 0; m_b = 1; m_k = 0; m_bz = 0; end
                3'd7: begin m_a = 0; m_b = 0; m_k = 1; m_bz = wr; end
                default: ;
            endcase
        end
        m_ctlq = ctl;
        @(negedge clk);
        compare(ltag);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tbl_stb = 0; tbl_wr = 0; ctl_line = 1; addr_hi = 0; key_avail = 0;
        m_cs = 8'hFF; m_a = 0; m_b = 0; m_k = 0; m_w = 0; m_bz = 0; m_ctlq = 1;
        @(negedge clk); @(negedge clk);
        compare("R10");
        rst = 1'b0;

        // sweep: prior state x region x direction
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 8; r++) begin
                for (int w = 0; w < 2; w++) begin
                    step(0, 3'd0, 0, 0, "R4");           // clear all select latches
                    step(0, 3'd0, 0, 1, "");
                    if (p > 0) step(1, 3'(4 + p), p[0], 1, "");
                    step(1, 3'(r), w[0], 1, (r < 5) ? "R9" : "");
                    step(0, 3'd0, 0, 1, (r < 5) ? "R9" : "");
                end
            end
        end

        // R4: strobe during low level is blocked
        step(0, 3'd0, 0, 1, "");
        step(1, 3'd7, 1, 0, "R4");
        step(1, 3'd5, 0, 0, "R4");
        step(0, 3'd0, 0, 1, "");

        // R5: low level without edge keeps wr; edge clears; set wins over edge
        step(1, 3'd2, 1, 1, "");
        step(0, 3'd0, 0, 0, "");
        step(1, 3'd3, 1, 0, "");
        step(0, 3'd0, 0, 0, "");
        step(0, 3'd0, 0, 1, "");
        step(1, 3'd6, 1, 0, "R4");
        step(0, 3'd0, 0, 1, "");
        step(0, 3'd0, 0, 0, "");

        // R8: buzz follows key latch, dropped by display select
        step(0, 3'd0, 0, 1, "");
        step(1, 3'd7, 1, 1, "");
        step(0, 3'd0, 0, 1, "");
        step(1, 3'd6, 0, 1, "");
        step(1, 3'd7, 0, 1, "");

        // R10: reset mid-run
        step(1, 3'd7, 1, 1, "");
        rst = 1'b1;
        tbl_stb = 1; addr_hi = 3'd5; tbl_wr = 1; ctl_line = 1;
        @(posedge clk);
        m_cs = 8'hFF; m_a = 0; m_b = 0; m_k = 0; m_w = 0; m_bz = 0; m_ctlq = 1;
        @(negedge clk);
        compare("R10");
        rst = 1'b0;
        step(0, 3'd0, 0, 1, "");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule